// File: doc/BRIEF.md
# Hot-Insertion Two-Wire Bus Connect Controller

This block sits between a backplane two-wire bus (clock and data) and the matching bus on a plug-in card. It holds the two sides apart until the card can join safely. The supply must be good and the enable input must be high. The backplane must then show the end of a transaction, either as a stop condition or as a long enough stretch of idle bus. Last, both card lines must read high. Only after all of these does the block join the buses and switch on the rise-time accelerator flag and the ready flag.

While joined, each line pair behaves as one wired-AND net. The block watches the sampled level of every line. When a device pulls one side low, the block pulls the other side low through that side's open-drain control. Clock stretching, arbitration and acknowledge therefore work across the boundary. Dropping enable or losing supply-good separates the sides on the next clock edge. Raising enable again starts the whole qualification from the beginning.

Top module: `hotbus_link`

## Requirements
- R1: While `supply_ok` is low, `link_on`, `accel_on` and `ready` stay low and all four pull-down outputs stay low, whatever the bus lines do, including a full stop condition or a long idle stretch.
- R2: Once out of lockout with `enable` high, a backplane stop condition brings `link_on` high within 8 cycles when the card lines are high. A stop condition is data going from low to high while clock is high on the samples before and after the data edge, with all bus inputs taken through a two-flop synchronizer.
- R3: If no stop is seen, `link_on` rises only after both backplane lines have stayed high for `IDLE_CYCLES` consecutive synchronized samples. A low on either backplane line restarts that count.
- R4: The block never links while either card line reads low, even after a stop or idle qualification. It links within 8 cycles of both card lines going high once qualified.
- R5: While linked, a low driven by a device on either side of a line pair makes both sides of that pair read low. The pull-down on side X is asserted only when side Y was low in the previous cycle.
- R6: A pair reads high on both sides only when every device on both sides has released it. No pull-down output is ever asserted while `link_on` is low.
- R7: `accel_on` is high exactly when `link_on` is high. `ready` is high only while `link_on` and `enable` are both high.
- R8: When `enable` is sampled low, `link_on`, `accel_on`, `ready` and all pull-downs are low after that clock edge, whatever the bus state. `ready` also falls combinationally with `enable`.
- R9: When `enable` returns high, the block does not relink at once. It needs a new stop or a full idle count, so on a quiet bus the relink takes at least `IDLE_CYCLES` cycles.
- R10: Loss of `supply_ok` at any time returns the block to lockout, and link, accelerator and ready are low after that edge. After supply-good returns, the full qualification is needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply above the under-voltage threshold |
| enable | input | 1 | Connect permission; low forces disconnect |
| bp_scl_i | input | 1 | Sampled level of the backplane clock line |
| bp_sda_i | input | 1 | Sampled level of the backplane data line |
| cd_scl_i | input | 1 | Sampled level of the card clock line |
| cd_sda_i | input | 1 | Sampled level of the card data line |
| link_on | output | 1 | Sides are joined |
| accel_on | output | 1 | Rise-time accelerators enabled |
| ready | output | 1 | Connection complete and enabled |
| bp_scl_pd | output | 1 | Pull backplane clock line low |
| bp_sda_pd | output | 1 | Pull backplane data line low |
| cd_scl_pd | output | 1 | Pull card clock line low |
| cd_sda_pd | output | 1 | Pull card data line low |

## Verification
Two functions can fall in the same clock edge: wired-AND forwarding and the disconnect caused by `enable` falling. The bench holds a card clock device low, so the backplane clock pull-down is active, and then drops `enable`. One cycle later it requires the backplane clock to read high again and the link to be off, so the pull-down cannot outlive the link by even one cycle. Randomized device pull-downs on both sides of both pairs are compared against the wired-AND of all drivers. Separate directed runs measure the cycle distance from the last backplane low or enable rise to the link. These runs check that the idle window restarts and is never cut short.

// File: rtl/hbj_pkg.sv
package hbj_pkg;

    typedef enum logic [1:0] {
        PH_LOCK = 2'd0,
        PH_HUNT = 2'd1,
        PH_CARD = 2'd2,
        PH_LINK = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        OWN_NONE   = 2'd0,
        OWN_A      = 2'd1,
        OWN_B      = 2'd2,
        OWN_SETTLE = 2'd3
    } owner_e;

    typedef struct packed {
        phase_e ph;
    } ctl_s;

    typedef struct packed {
        owner_e own;
    } pair_s;

endpackage

// File: rtl/hbj_sync.sv
module hbj_sync #(
    parameter int W     = 4,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [DEPTH-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < DEPTH; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    // lines idle high, so the chain resets to ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '1;
        else        stg_q <= stg_d;
    end

    assign q = stg_q[DEPTH-1];
endmodule

// File: rtl/hbj_endwatch.sv
module hbj_endwatch #(
    parameter int IDLE_CYCLES = 9500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic scl_i,
    input  logic sda_i,
    output logic stop_hit,
    output logic idle_hit
);
    localparam int CW = $clog2(IDLE_CYCLES + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(IDLE_CYCLES);

    typedef struct packed {
        logic          scl_prev;
        logic          sda_prev;
        logic [CW-1:0] cnt;
    } ew_s;

    ew_s ew_d, ew_q;

    always_comb begin
        ew_d          = ew_q;
        ew_d.scl_prev = scl_i;
        ew_d.sda_prev = sda_i;
        if (clr || !scl_i || !sda_i) begin
            ew_d.cnt = '0;
        end else if (ew_q.cnt != CNT_TOP) begin
            ew_d.cnt = ew_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ew_q <= '{scl_prev: 1'b1, sda_prev: 1'b1, cnt: '0};
        else        ew_q <= ew_d;
    end

    // data low->high with clock high on both neighbouring samples
    assign stop_hit = ew_q.scl_prev & scl_i & ~ew_q.sda_prev & sda_i;
    assign idle_hit = (ew_q.cnt == CNT_TOP);

    AST_IDLE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        idle_hit |-> ($past(scl_i) && $past(sda_i)));   // R3
endmodule

// File: rtl/hbj_pair.sv
module hbj_pair
    import hbj_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic a_lvl,
    input  logic b_lvl,
    output logic a_pd,
    output logic b_pd
);
    pair_s pr_d, pr_q;

    always_comb begin
        pr_d = pr_q;
        if (!active) begin
            pr_d.own = OWN_NONE;
        end else begin
            unique case (pr_q.own)
                OWN_NONE: begin
                    if (!a_lvl)      pr_d.own = OWN_A;
                    else if (!b_lvl) pr_d.own = OWN_B;
                end
                OWN_A:      if (a_lvl) pr_d.own = OWN_SETTLE;
                OWN_B:      if (b_lvl) pr_d.own = OWN_SETTLE;
                OWN_SETTLE: pr_d.own = OWN_NONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pr_q <= '{own: OWN_NONE};
        else        pr_q <= pr_d;
    end

    // the side that pulled low first is echoed onto the other side
    assign b_pd = (pr_q.own == OWN_A);
    assign a_pd = (pr_q.own == OWN_B);

    AST_FWD_SRC_A: assert property (@(posedge clk) disable iff (!rst_n)
        a_pd |-> $past(!b_lvl));   // R5
    AST_FWD_SRC_B: assert property (@(posedge clk) disable iff (!rst_n)
        b_pd |-> $past(!a_lvl));   // R5
    AST_PAIR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!a_pd && !b_pd));   // R6
endmodule

// File: rtl/hotbus_link.sv
module hotbus_link
    import hbj_pkg::*;
#(
    parameter int IDLE_CYCLES = 9500,
    parameter int SYNC_DEPTH  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic enable,
    input  logic bp_scl_i,
    input  logic bp_sda_i,
    input  logic cd_scl_i,
    input  logic cd_sda_i,
    output logic link_on,
    output logic accel_on,
    output logic ready,
    output logic bp_scl_pd,
    output logic bp_sda_pd,
    output logic cd_scl_pd,
    output logic cd_sda_pd
);
    localparam int NPAIR = 2;
    localparam int NLINE = 2 * NPAIR;

    logic [NLINE-1:0] raw_lvl, syn_lvl;
    logic [NPAIR-1:0] bp_lvl, cd_lvl, bp_pd, cd_pd;
    logic             stop_hit, idle_hit, clr_idle, card_hi, pair_active;
    ctl_s             st_d, st_q;

    assign bp_lvl  = {bp_sda_i, bp_scl_i};
    assign cd_lvl  = {cd_sda_i, cd_scl_i};
    assign raw_lvl = {cd_lvl, bp_lvl};

    hbj_sync #(.W(NLINE), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_lvl),
        .q     (syn_lvl)
    );

    hbj_endwatch #(.IDLE_CYCLES(IDLE_CYCLES)) u_end (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_idle),
        .scl_i    (syn_lvl[0]),
        .sda_i    (syn_lvl[1]),
        .stop_hit (stop_hit),
        .idle_hit (idle_hit)
    );

    assign card_hi  = syn_lvl[2] & syn_lvl[3];
    assign clr_idle = (st_q.ph != PH_HUNT) || !enable;

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_LOCK: if (supply_ok) st_d.ph = PH_HUNT;
            PH_HUNT: if (enable && (stop_hit || idle_hit)) st_d.ph = PH_CARD;
            PH_CARD: if (card_hi) st_d.ph = PH_LINK;
            PH_LINK: st_d.ph = PH_LINK;
        endcase
        if (!enable && st_q.ph != PH_LOCK) st_d.ph = PH_HUNT;
        if (!supply_ok)                    st_d.ph = PH_LOCK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_LOCK};
        else        st_q <= st_d;
    end

    // pairs follow the next phase so their pull-downs leave with the link
    assign pair_active = (st_d.ph == PH_LINK);

    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        hbj_pair u_pair (
            .clk    (clk),
            .rst_n  (rst_n),
            .active (pair_active),
            .a_lvl  (bp_lvl[k]),
            .b_lvl  (cd_lvl[k]),
            .a_pd   (bp_pd[k]),
            .b_pd   (cd_pd[k])
        );
    end

    assign link_on   = (st_q.ph == PH_LINK);
    assign accel_on  = link_on;
    assign ready     = link_on & enable;
    assign bp_scl_pd = bp_pd[0];
    assign bp_sda_pd = bp_pd[1];
    assign cd_scl_pd = cd_pd[0];
    assign cd_sda_pd = cd_pd[1];

    AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!link_on && !accel_on && !ready));   // R10
    AST_EN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !link_on);   // R8
    AST_UNLINKED_NO_PD: assert property (@(posedge clk) disable iff (!rst_n)
        !link_on |-> !(bp_scl_pd || bp_sda_pd || cd_scl_pd || cd_sda_pd));   // R6
    AST_LINK_CARD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_on) |-> $past(card_hi));   // R4
endmodule

// File: tb/hotbus_link_test.sv
module hotbus_link_test;
    localparam int IDLE = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic enable = 1'b1;
    logic bp_scl_dev = 1'b0, bp_sda_dev = 1'b0, cd_scl_dev = 1'b0, cd_sda_dev = 1'b0;
    logic link_on, accel_on, ready;
    logic bp_scl_pd, bp_sda_pd, cd_scl_pd, cd_sda_pd;
    logic bp_scl, bp_sda, cd_scl, cd_sda;
    int   total = 0;
    int   bad = 0;

    always #5 clk = ~clk;

    assign bp_scl = ~(bp_scl_dev | bp_scl_pd);
    assign bp_sda = ~(bp_sda_dev | bp_sda_pd);
    assign cd_scl = ~(cd_scl_dev | cd_scl_pd);
    assign cd_sda = ~(cd_sda_dev | cd_sda_pd);

    hotbus_link #(.IDLE_CYCLES(IDLE)) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .enable(enable),
        .bp_scl_i(bp_scl), .bp_sda_i(bp_sda), .cd_scl_i(cd_scl), .cd_sda_i(cd_sda),
        .link_on(link_on), .accel_on(accel_on), .ready(ready),
        .bp_scl_pd(bp_scl_pd), .bp_sda_pd(bp_sda_pd),
        .cd_scl_pd(cd_scl_pd), .cd_sda_pd(cd_sda_pd)
    );

    function automatic logic wired(input logic dev_a, input logic dev_b);
        return !(dev_a || dev_b);
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int v, input int lo, input int hi);
        total++;
        if (v < lo || v > hi) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d..%0d", tag, v, lo, hi);
        end
    endtask

    task automatic wait_link(input int lim, output int n);
        n = 0;
        while (!link_on && n < lim) begin
            step(1);
            n++;
        end
    endtask

    task automatic do_stop();
        bp_sda_dev = 1'b1; step(3);
        bp_scl_dev = 1'b1; step(3);
        bp_scl_dev = 1'b0; step(3);
        bp_sda_dev = 1'b0;
    endtask

    task automatic no_pd(input string tag);
        chk(tag, bp_scl_pd | bp_sda_pd | cd_scl_pd | cd_sda_pd, 1'b0);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=hang exp=done");
        finish_run();
    end

    initial begin
        int n;
        void'($urandom(32'd4242));
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1 reset link", link_on, 1'b0);
        chk("R1 reset ready", ready, 1'b0);
        chk("R1 reset accel", accel_on, 1'b0);
        no_pd("R1 reset pulldowns");

        // lockout: stop and long idle are ignored
        do_stop();
        step(IDLE + 20);
        chk("R1 lockout link", link_on, 1'b0);
        no_pd("R1 lockout pulldowns");

        // stop condition qualifies well before the idle window
        supply_ok = 1'b1;
        do_stop();
        wait_link(12, n);
        chk_rng("R2 stop to link cycles", n, 2, 8);
        chk("R7 accel with link", accel_on, 1'b1);
        chk("R7 ready with link", ready, 1'b1);

        // directed forwarding in both directions
        bp_scl_dev = 1'b1; step(3);
        chk("R5 bp clock low reaches card", cd_scl, 1'b0);
        bp_scl_dev = 1'b0; step(3);
        chk("R6 clock released both high bp", bp_scl, 1'b1);
        chk("R6 clock released both high card", cd_scl, 1'b1);
        cd_sda_dev = 1'b1; step(3);
        chk("R5 card data low reaches bp", bp_sda, 1'b0);
        cd_sda_dev = 1'b0; step(3);
        // clock stretching on the card after the backplane lets go
        bp_scl_dev = 1'b1; cd_scl_dev = 1'b1; step(3);
        bp_scl_dev = 1'b0; step(5);
        chk("R6 stretched clock holds bp low", bp_scl, 1'b0);
        chk("R6 stretched clock holds card low", cd_scl, 1'b0);
        cd_scl_dev = 1'b0; step(5);
        chk("R6 stretch end bp high", bp_scl, 1'b1);
        chk("R6 stretch end card high", cd_scl, 1'b1);

        // randomized device activity on all four lines
        for (int i = 0; i < 150; i++) begin
            logic [3:0] r;
            r = 4'($urandom());
            {cd_sda_dev, cd_scl_dev, bp_sda_dev, bp_scl_dev} = r;
            step(6);
            chk("R5 random bp clock", bp_scl, wired(bp_scl_dev, cd_scl_dev));
            chk("R5 random card clock", cd_scl, wired(bp_scl_dev, cd_scl_dev));
            chk("R5 random bp data", bp_sda, wired(bp_sda_dev, cd_sda_dev));
            chk("R5 random card data", cd_sda, wired(bp_sda_dev, cd_sda_dev));
        end
        {cd_sda_dev, cd_scl_dev, bp_sda_dev, bp_scl_dev} = 4'b0;
        step(6);
        chk("R7 still linked after traffic", link_on, 1'b1);

        // enable drop while a forwarded low is active
        cd_scl_dev = 1'b1; step(4);
        chk("R5 bp clock pulled before drop", bp_scl_pd, 1'b1);
        enable = 1'b0;
        #1;
        chk("R8 ready falls with enable", ready, 1'b0);
        step(1);
        chk("R8 link off one cycle after drop", link_on, 1'b0);
        chk("R8 accel off one cycle after drop", accel_on, 1'b0);
        chk("R8 bp clock freed at drop", bp_scl, 1'b1);
        no_pd("R6 no pulldown after drop");
        cd_scl_dev = 1'b0;
        step(3);

        // enable back high: full idle window needed again
        enable = 1'b1;
        step(IDLE / 2);
        chk("R9 no early relink", link_on, 1'b0);
        wait_link(IDLE + 20, n);
        chk_rng("R9 relink cycles", n + IDLE / 2, IDLE, IDLE + 10);

        // a backplane low restarts the idle window
        enable = 1'b0; step(2);
        enable = 1'b1; step(IDLE / 2);
        bp_scl_dev = 1'b1; step(2);
        bp_scl_dev = 1'b0;
        wait_link(IDLE + 30, n);
        chk_rng("R3 idle restart cycles", n, IDLE, IDLE + 10);

        // card line low blocks the link after qualification
        enable = 1'b0; step(2);
        cd_sda_dev = 1'b1;
        enable = 1'b1;
        step(IDLE + 20);
        chk("R4 card low blocks link", link_on, 1'b0);
        cd_sda_dev = 1'b0;
        wait_link(12, n);
        chk_rng("R4 card release to link", n, 1, 8);

        // supply loss returns to lockout
        supply_ok = 1'b0;
        step(1);
        chk("R10 link off after supply loss", link_on, 1'b0);
        chk("R10 ready off after supply loss", ready, 1'b0);
        chk("R10 accel off after supply loss", accel_on, 1'b0);
        step(3);
        supply_ok = 1'b1;
        wait_link(IDLE + 20, n);
        chk_rng("R10 requalify after supply", n, IDLE, IDLE + 10);

        finish_run();
    end
endmodule